// File: doc/BRIEF.md
# On-Screen Text Overlay Engine

This block draws one short line of characters over a live RGB pixel stream. Typical use is labelling a video feed with a channel number. It sits in the pixel clock domain, after the timing generator and before the link encoder. For each pixel it receives the colour, the horizontal and vertical syncs, the data-enable flag and the pixel's x/y counters. Wherever a set glyph pixel falls on the screen, the block replaces the incoming pixel with one solid colour picked from a 16-entry palette. All other pixels pass through untouched.

The text line is set by a few quasi-static control inputs. An 8-bit position word gives the first text row and column. A 2-bit size code magnifies the glyphs. A 4-bit colour code picks the ink. There are seven 4-bit character codes and a 3-bit count of how many of them are shown. Glyphs come from a built-in seven-segment style font for the hexadecimal digits 0 to F, which is computed rather than stored. The syncs and data-enable go through the same two register stages as the pixel data, so timing at the output stays aligned.

Top module: `osdOverlay`

## Requirements
- R1: While rstN is low, rgbOut, hsOut, vsOut and deOut are all zero.
- R2: The text box's top row is 4*startPos[7:4]+8 and its leftmost column is 4*startPos[3:0]+20, both in pixel counter units.
- R3: With size code s in sizeSel, each glyph cell is 8 by 8 base pixels and each base pixel covers (s+1) by (s+1) screen pixels, so a character cell spans 8*(s+1) pixels in each direction.
- R4: Colour codes 0 to 5 give {R,G,B} = ff0000, 00ff00, 0000ff, ffff00, ff00ff and 00ffff, in that order; rgbOut is packed as {R[23:16], G[15:8], B[7:0]}.
- R5: Colour codes 6 to 15 give a grey with R=G=B=16*(code-5), that is 0x10 up to 0xa0.
- R6: Character k (k = 0 to 6) occupies the k-th cell from the left, with no gap between cells. A character is drawn only if k < charCount, so a count of 0 draws nothing.
- R7: When osdEn is 0, rgbOut equals rgbIn delayed by two clocks.
- R8: hsOut, vsOut, deOut and rgbOut follow the inputs applied exactly two clock edges earlier.
- R9: A pixel whose deIn is 0 is never painted; its colour passes through unchanged.
- R10: Character k's code is charCodes[4k+3:4k] and shows hex digit 0 to F as segments whose bits 0 to 6 of 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 are lit, using glyph row r and column c (0 to 7). The segments are drawn as follows:
  - bit0 is r=0, c=1..5.
  - bit1 is c=5, r=0..3.
  - bit2 is c=5, r=3..6.
  - bit3 is r=6, c=1..5.
  - bit4 is c=1, r=3..6.
  - bit5 is c=1, r=0..3.
  - bit6 is r=3, c=1..5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| osdEn | input | 1 | Overlay enable |
| startPos | input | 8 | Text position word: row nibble high, column nibble low |
| sizeSel | input | 2 | Glyph magnification code |
| colorSel | input | 4 | Palette index for the text ink |
| charCodes | input | 28 | Seven 4-bit character codes, character 0 in the low bits |
| charCount | input | 3 | Number of characters shown |
| pixX | input | 12 | Horizontal pixel counter of the incoming pixel |
| pixY | input | 12 | Vertical pixel counter of the incoming pixel |
| rgbIn | input | 24 | Incoming pixel colour |
| hsIn | input | 1 | Incoming horizontal sync |
| vsIn | input | 1 | Incoming vertical sync |
| deIn | input | 1 | Incoming data-enable |
| rgbOut | output | 24 | Overlaid pixel colour |
| hsOut | output | 1 | Horizontal sync, delayed |
| vsOut | output | 1 | Vertical sync, delayed |
| deOut | output | 1 | Data-enable, delayed |

## Verification
The block holds state only in its two pipeline stages, so any internal fault shows up at the ports within two clocks of the pixel that caused it. A wrong stage-one strobe shows as ink on the wrong pixel or a missing glyph segment. A misaligned stage shows as a whole glyph shifted by one column, or as a sync edge that no longer lines up with its pixel. A fault in the divide-by-scale path breaks the cell width for only one size code. For that reason every size code is scanned over a full character line, with margins around the text box, and each output pixel is compared against a model built from the requirements.

// File: rtl/osdPkg.sv
package osdPkg;
  localparam int COMP_W = 8;
  localparam int RGB_W  = 3 * COMP_W;
  localparam int CODE_W = 4;
  localparam int CELL   = 8;

  typedef struct packed {
    logic paint;
  } osdStrobe_t;

  // Ink colour for a palette index: six saturated hues, then ten grey steps.
  function automatic logic [RGB_W-1:0] paletteRgb(input logic [3:0] idx);
    logic [COMP_W-1:0] grey;
    grey = COMP_W'(({4'd0, idx} - 8'd5) << 4);
    case (idx)
      4'd0:    return 24'hff0000;
      4'd1:    return 24'h00ff00;
      4'd2:    return 24'h0000ff;
      4'd3:    return 24'hffff00;
      4'd4:    return 24'hff00ff;
      4'd5:    return 24'h00ffff;
      default: return {grey, grey, grey};
    endcase
  endfunction

  // Segment set for a hex digit, bit 0 = top bar ... bit 6 = middle bar.
  function automatic logic [6:0] segMap(input logic [3:0] code);
    case (code)
      4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
      4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
      4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
      4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
    endcase
  endfunction

  function automatic logic glyphBit(input logic [3:0] code, input logic [2:0] r,
                                    input logic [2:0] c);
    logic [6:0] s;
    logic bar, upper, lower;
    s     = segMap(code);
    bar   = (c >= 3'd1) && (c <= 3'd5);
    upper = (r <= 3'd3);
    lower = (r >= 3'd3) && (r <= 3'd6);
    return (s[0] && r == 3'd0 && bar) || (s[1] && c == 3'd5 && upper) ||
           (s[2] && c == 3'd5 && lower) || (s[3] && r == 3'd6 && bar) ||
           (s[4] && c == 3'd1 && lower) || (s[5] && c == 3'd1 && upper) ||
           (s[6] && r == 3'd3 && bar);
  endfunction
endpackage

// File: rtl/osdCtrl.sv
module osdCtrl
  import osdPkg::*;
#(
  parameter int PW    = 12,
  parameter int NCHAR = 7,
  parameter int CNTW  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    osdEn,
  input  logic [7:0]              startPos,
  input  logic [1:0]              sizeSel,
  input  logic [NCHAR*CODE_W-1:0] charCodes,
  input  logic [CNTW-1:0]         charCount,
  input  logic [PW-1:0]           pixX,
  input  logic [PW-1:0]           pixY,
  input  logic                    deIn,
  output osdStrobe_t              strobeQ
);
  localparam int IDXW = PW - 3;

  logic [PW-1:0]     rowStart, colStart, dx, dy, qx, qy;
  logic [IDXW-1:0]   charIdx;
  logic [CODE_W-1:0] code;
  logic              inRows, inCols, inBox, paintNext;

  function automatic logic [PW-1:0] unscale(input logic [PW-1:0] v, input logic [1:0] s);
    case (s)
      2'd0:    return v;
      2'd1:    return v >> 1;
      2'd2:    return v / PW'(3);
      default: return v >> 2;
    endcase
  endfunction

  assign rowStart = PW'({startPos[7:4], 2'b00}) + PW'(8);
  assign colStart = PW'({startPos[3:0], 2'b00}) + PW'(20);

  always_comb begin
    inRows  = pixY >= rowStart;
    inCols  = pixX >= colStart;
    dy      = pixY - rowStart;
    dx      = pixX - colStart;
    qy      = unscale(dy, sizeSel);
    qx      = unscale(dx, sizeSel);
    charIdx = qx[PW-1:3];
    code    = '0;
    for (int i = 0; i < NCHAR; i++)
      if (charIdx == IDXW'(i)) code = charCodes[i*CODE_W +: CODE_W];
    inBox     = inRows && inCols && (qy < PW'(CELL)) && (charIdx < IDXW'(charCount));
    paintNext = osdEn && deIn && inBox && glyphBit(code, qy[2:0], qx[2:0]);
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) strobeQ <= '0;
    else       strobeQ.paint <= paintNext;
endmodule

// File: rtl/osdData.sv
module osdData
  import osdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  osdStrobe_t       strobe,
  input  logic [3:0]       colorSel,
  input  logic [RGB_W-1:0] rgbIn,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic             deIn,
  output logic [RGB_W-1:0] rgbOut,
  output logic             hsOut,
  output logic             vsOut,
  output logic             deOut
);
  logic [RGB_W-1:0] rgbD;
  logic [2:0]       syncD;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rgbD   <= '0;
      syncD  <= '0;
      rgbOut <= '0;
      {hsOut, vsOut, deOut} <= '0;
    end else begin
      rgbD   <= rgbIn;
      syncD  <= {hsIn, vsIn, deIn};
      rgbOut <= strobe.paint ? paletteRgb(colorSel) : rgbD;
      {hsOut, vsOut, deOut} <= syncD;
    end
endmodule

// File: rtl/osdOverlay.sv
module osdOverlay
  import osdPkg::*;
#(
  parameter int PW    = 12,
  parameter int NCHAR = 7,
  localparam int CNTW = $clog2(NCHAR + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    osdEn,
  input  logic [7:0]              startPos,
  input  logic [1:0]              sizeSel,
  input  logic [3:0]              colorSel,
  input  logic [NCHAR*CODE_W-1:0] charCodes,
  input  logic [CNTW-1:0]         charCount,
  input  logic [PW-1:0]           pixX,
  input  logic [PW-1:0]           pixY,
  input  logic [RGB_W-1:0]        rgbIn,
  input  logic                    hsIn,
  input  logic                    vsIn,
  input  logic                    deIn,
  output logic [RGB_W-1:0]        rgbOut,
  output logic                    hsOut,
  output logic                    vsOut,
  output logic                    deOut
);
  osdStrobe_t strobe;

  osdCtrl #(.PW(PW), .NCHAR(NCHAR), .CNTW(CNTW)) uCtrl (
    .clk(clk), .rstN(rstN), .osdEn(osdEn), .startPos(startPos), .sizeSel(sizeSel),
    .charCodes(charCodes), .charCount(charCount), .pixX(pixX), .pixY(pixY),
    .deIn(deIn), .strobeQ(strobe)
  );

  osdData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .colorSel(colorSel), .rgbIn(rgbIn),
    .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn), .rgbOut(rgbOut), .hsOut(hsOut),
    .vsOut(vsOut), .deOut(deOut)
  );
endmodule

// File: rtl/osdOverlayChk.sv
module osdOverlayChk #(
  parameter int CNTW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            osdEn,
  input logic [CNTW-1:0] charCount,
  input logic [23:0]     rgbIn,
  input logic            hsIn,
  input logic            vsIn,
  input logic            deIn,
  input logic [23:0]     rgbOut,
  input logic            hsOut,
  input logic            vsOut,
  input logic            deOut
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;

  always @(negedge clk)
    if (!rstN) AST_RESET_QUIET: assert (rgbOut == '0 && !hsOut && !vsOut && !deOut); // R1

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2) |-> ({hsOut, vsOut, deOut} == $past({hsIn, vsIn, deIn}, 2))); // R8
  AST_BLANK_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2 && !deOut) |-> (rgbOut == $past(rgbIn, 2))); // R9
  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2 && !$past(osdEn, 2)) |-> (rgbOut == $past(rgbIn, 2))); // R7
  AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2 && $past(charCount, 2) == '0) |-> (rgbOut == $past(rgbIn, 2))); // R6
endmodule

bind osdOverlay osdOverlayChk #(.CNTW(CNTW)) uChk (
  .clk(clk), .rstN(rstN), .osdEn(osdEn), .charCount(charCount), .rgbIn(rgbIn),
  .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn), .rgbOut(rgbOut), .hsOut(hsOut),
  .vsOut(vsOut), .deOut(deOut)
);

// File: tb/sim_osdOverlay.sv
module sim_osdOverlay;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        osdEn = 1'b0;
  logic [7:0]  startPos = '0;
  logic [1:0]  sizeSel = '0;
  logic [3:0]  colorSel = '0;
  logic [27:0] charCodes = '0;
  logic [2:0]  charCount = '0;
  logic [11:0] pixX = '0, pixY = '0;
  logic [23:0] rgbIn = '0;
  logic        hsIn = 1'b0, vsIn = 1'b0, deIn = 1'b0;
  logic [23:0] rgbOut;
  logic        hsOut, vsOut, deOut;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // expectation history: slot 0 = applied one edge ago, slot 1 = two edges ago
  logic [26:0] expQ [2];
  bit          expV [2];
  string       expTag [2];

  always #10 clk = ~clk;

  osdOverlay u0 (
    .clk(clk), .rstN(rstN), .osdEn(osdEn), .startPos(startPos), .sizeSel(sizeSel),
    .colorSel(colorSel), .charCodes(charCodes), .charCount(charCount), .pixX(pixX),
    .pixY(pixY), .rgbIn(rgbIn), .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn),
    .rgbOut(rgbOut), .hsOut(hsOut), .vsOut(vsOut), .deOut(deOut)
  );

  function automatic logic [23:0] inkOf(int idx);
    int g;
    case (idx)
      0: return 24'hff0000;
      1: return 24'h00ff00;
      2: return 24'h0000ff;
      3: return 24'hffff00;
      4: return 24'hff00ff;
      5: return 24'h00ffff;
      default: begin
        g = 16 * (idx - 5);
        return {g[7:0], g[7:0], g[7:0]};
      end
    endcase
  endfunction

  function automatic bit litPixel(int code, int r, int c);
    logic [6:0] seg;
    logic [6:0] lut [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                             7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    seg = lut[code];
    if (c >= 1 && c <= 5) begin
      if (r == 0 && seg[0]) return 1;
      if (r == 3 && seg[6]) return 1;
      if (r == 6 && seg[3]) return 1;
    end
    if (c == 5 && ((r <= 3 && seg[1]) || (r >= 3 && r <= 6 && seg[2]))) return 1;
    if (c == 1 && ((r <= 3 && seg[5]) || (r >= 3 && r <= 6 && seg[4]))) return 1;
    return 0;
  endfunction

  function automatic bit wantInk(int x, int y, bit de);
    int s, top, left, l;
    if (!osdEn || !de) return 0;
    s    = int'(sizeSel) + 1;
    top  = 4 * int'(startPos[7:4]) + 8;
    left = 4 * int'(startPos[3:0]) + 20;
    if (y < top || y >= top + 8 * s) return 0;
    for (int k = 0; k < int'(charCount); k++) begin
      l = left + 8 * s * k;
      if (x >= l && x < l + 8 * s)
        return litPixel(int'(charCodes[4*k +: 4]), (y - top) / s, (x - l) / s);
    end
    return 0;
  endfunction

  task automatic drivePix(int x, int y, bit de, string tag);
    logic [23:0] px;
    bit hs, vs;
    @(negedge clk);
    if (expV[1]) begin
      nChecks++;
      if ({rgbOut, hsOut, vsOut, deOut} !== expQ[1]) begin
        nFails++;
        $display("FAIL %s: out rgb/hs/vs/de act=%h/%b/%b/%b exp=%h/%b/%b/%b",
                 expTag[1], rgbOut, hsOut, vsOut, deOut, expQ[1][26:3],
                 expQ[1][2], expQ[1][1], expQ[1][0]);
      end
    end
    px = {x[7:0], y[7:0], 8'h5a ^ x[7:0]};
    hs = (x % 13) == 0;
    vs = y[0];
    expQ[1]   = expQ[0];  expV[1] = expV[0];  expTag[1] = expTag[0];
    expQ[0]   = {wantInk(x, y, de) ? inkOf(int'(colorSel)) : px, hs, vs, de};
    expV[0]   = 1'b1;
    expTag[0] = tag;
    pixX = 12'(x);  pixY = 12'(y);  rgbIn = px;  hsIn = hs;  vsIn = vs;  deIn = de;
  endtask

  // deMode 1 drops data-enable on every third pixel
  task automatic scanBox(string tag, int deMode);
    int s, top, left, n;
    s    = int'(sizeSel) + 1;
    top  = 4 * int'(startPos[7:4]) + 8;
    left = 4 * int'(startPos[3:0]) + 20;
    n    = (charCount == 0) ? 2 : int'(charCount) + 1;
    for (int y = top - 2; y < top + 8 * s + 2; y++)
      for (int x = left - 2; x < left + 8 * s * n + 2; x++)
        drivePix(x, y, deMode == 0 ? 1'b1 : ((x + y) % 3 != 0), tag);
    drivePix(0, 0, 1'b0, tag);
    drivePix(0, 0, 1'b0, tag);
  endtask

  task automatic setCfg(bit en, logic [7:0] pos, int sz, int col, logic [27:0] codes, int cnt);
    osdEn = en;  startPos = pos;  sizeSel = 2'(sz);  colorSel = 4'(col);
    charCodes = codes;  charCount = 3'(cnt);
  endtask

  task automatic testReset();
    rgbIn = 24'hffffff;  hsIn = 1;  vsIn = 1;  deIn = 1;  osdEn = 1;
    repeat (3) @(negedge clk);
    nChecks++;
    if ({rgbOut, hsOut, vsOut, deOut} !== 27'd0) begin
      nFails++;
      $display("FAIL R1: outputs in reset act=%h exp=0", {rgbOut, hsOut, vsOut, deOut});
    end
    rstN = 1'b1;
  endtask

  task automatic testBasic();   // R10 R6 R4 R8 R2
    setCfg(1, 8'h00, 0, 0, 28'h0000321, 3);
    scanBox("R10/R6/R8 digits 1-2-3 red", 0);
  endtask

  task automatic testLargeGrey();   // R3 R5 R2
    setCfg(1, 8'h21, 3, 15, 28'h7654308, 7);
    scanBox("R3/R5/R2 size3 grey a0", 0);
  endtask

  task automatic testThirdScale();   // R3 R10 R4
    setCfg(1, 8'h13, 2, 4, 28'h0FEDCBA, 7);
    scanBox("R3/R10 size2 hex letters magenta", 0);
  endtask

  task automatic testBlanking();   // R9
    setCfg(1, 8'h32, 1, 2, 28'h8888888, 5);
    scanBox("R9 data-enable gaps", 1);
  endtask

  task automatic testDisabled();   // R7
    setCfg(0, 8'h00, 0, 3, 28'h8888888, 7);
    scanBox("R7 overlay disabled", 0);
  endtask

  task automatic testCountZero();   // R6
    setCfg(1, 8'h00, 0, 1, 28'h8888888, 0);
    scanBox("R6 count zero", 0);
  endtask

  task automatic testPalette();   // R4 R5
    for (int c = 0; c < 16; c++) begin
      setCfg(1, 8'h44, 0, c, 28'h0000008, 1);
      scanBox(c < 6 ? "R4 palette hue" : "R5 palette grey", 0);
    end
  endtask

  task automatic finishRun();
    if (done) return;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    expV[0] = 0;  expV[1] = 0;
    testReset();
    testBasic();
    testLargeGrey();
    testThirdScale();
    testBlanking();
    testDisabled();
    testCountZero();
    testPalette();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run act=hung exp=complete");
    finishRun();
  end
endmodule